// File: doc/BRIEF.md
# Autovector Acknowledge Generator

This block produces the active-low autovector request for a 68000-family processor. When the processor runs an interrupt acknowledge cycle and an older peripheral answers with the valid-peripheral-address signal instead of putting a vector on the bus, the processor needs an autovector request. This block generates that request. The block sits between the processor strobes and the interrupt logic. All of its state changes on the falling edge of the 8 MHz bus clock.

Recognition takes two registered stages. The qualifier stage captures one term: function code all ones, the peripheral answer asserted, and the high address nibble all ones. A three-state sequencer then drives the request: IDLE, DRIVE and LOCKED. The transitions are:

- FIRE (IDLE to DRIVE): the captured term is true, the legacy acknowledge line is high and the address strobe is low.
- DROP (DRIVE to LOCKED): the qualification goes away while the strobe is still low.
- RELEASE (DRIVE or LOCKED to IDLE): the strobe is sampled high.

The LOCKED state keeps the request from firing a second time inside one acknowledge cycle. A second request in the same cycle would upset the system.

Top module: `avec_ack_gen`

## Requirements
- R1: While rst_n is low, avec_n is high. Both the qualifier stage and the sequencer return to their cleared state, immediately and without waiting for a clock edge.
- R2: The qualifier stage registers true on a falling clock edge only when all of the following hold: fc equals 3'b111, vpa_n is 0, and addr_hi equals 4'b1111. If any single bit differs, no request follows.
- R3: Suppose the qualifying inputs and as_n=0 are first sampled on falling edge N, and dtack_lvl is 1. Then avec_n is still 1 after edge N and becomes 0 after edge N+1. That is two falling edges from recognition to the request.
- R4: avec_n can go low only on a falling edge where the qualifier is true, dtack_lvl is 1 and as_n is 0. With dtack_lvl at 0, no request is made.
- R5: avec_n returns to 1 on the first falling edge at which as_n is sampled high (RELEASE).
- R6: Within one interval of as_n low, avec_n goes low at most once.
- R7: Once asserted, avec_n returns high on the first falling edge at which the qualifier is false or dtack_lvl is 0 (DROP). It stays high until as_n has been sampled high, even if the qualification comes back.
- R8: After a RELEASE, the next acknowledge cycle, with only one clock of strobe high in between, produces a new request with the timing of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk8 | input | 1 | Bus clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc | input | 3 | Processor function code |
| addr_hi | input | 4 | Address bits 19 down to 16 |
| vpa_n | input | 1 | Active-low valid-peripheral-address answer |
| as_n | input | 1 | Active-low processor address strobe |
| dtack_lvl | input | 1 | Legacy bus acknowledge level; must be high for a request |
| avec_n | output | 1 | Registered active-low autovector request |

## Verification
The bench tries several kinds of cycle, and each one tells a different thing apart:

- Clean acknowledge cycles show whether the two-edge latency is right.
- Acknowledge cycles with the legacy acknowledge line held low show whether that line really gates the request.
- Memory cycles that miss the decode by one function-code or address bit show whether the qualifier matches the whole pattern.
- Acknowledge cycles in which the peripheral answer drops for one clock and then returns separate a design with a lockout from one that fires twice.
- Back-to-back acknowledge cycles separated by a single idle clock show that the lockout is cleared on the strobe and not later.

A cycle-level reference model in the bench predicts every sample, and the bench also counts pulses for each strobe interval.

// File: rtl/avec_pkg.sv
package avec_pkg;

    parameter int FC_W   = 3;
    parameter int ADDR_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRIVE  = 2'd1,
        ST_LOCKED = 2'd2
    } avec_state_e;

endpackage

// File: rtl/avec_qualify.sv
module avec_qualify #(
    parameter int FC_W   = avec_pkg::FC_W,
    parameter int ADDR_W = avec_pkg::ADDR_W
) (
    input  logic              clk8,
    input  logic              rst_n,
    input  logic [FC_W-1:0]   fc,
    input  logic [ADDR_W-1:0] addr_hi,
    input  logic              vpa_n,
    output logic              qual_q
);

    localparam logic [FC_W-1:0]   ACK_FC   = {FC_W{1'b1}};
    localparam logic [ADDR_W-1:0] ACK_ADDR = {ADDR_W{1'b1}};

    logic hit;

    always_comb begin
        hit = (fc == ACK_FC) && (addr_hi == ACK_ADDR) && !vpa_n;
    end

    always_ff @(negedge clk8 or negedge rst_n) begin
        if (!rst_n) qual_q <= 1'b0;
        else        qual_q <= hit;
    end

    // R2: a true stage output always traces back to the full pattern one edge before
    p_stage_pattern_r2: assert property (@(negedge clk8) disable iff (!rst_n)
        qual_q |-> $past((fc == ACK_FC) && (addr_hi == ACK_ADDR) && !vpa_n));

endmodule

// File: rtl/avec_lockout_fsm.sv
module avec_lockout_fsm
    import avec_pkg::*;
(
    input  logic clk8,
    input  logic rst_n,
    input  logic qual_q,
    input  logic dtack_lvl,
    input  logic as_n,
    output logic avec_n
);

    avec_state_e state_q, state_d;
    logic        fire_ok;

    always_comb begin
        fire_ok = qual_q && dtack_lvl && !as_n;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (fire_ok) state_d = ST_DRIVE;               // FIRE
            ST_DRIVE:  if (as_n) state_d = ST_IDLE;                   // RELEASE
                       else if (!fire_ok) state_d = ST_LOCKED;        // DROP
            ST_LOCKED: if (as_n) state_d = ST_IDLE;                   // RELEASE
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(negedge clk8 or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        avec_n = (state_q != ST_DRIVE);
    end

    // R4: a request only starts after the full firing condition was sampled
    p_fire_cause_r4: assert property (@(negedge clk8) disable iff (!rst_n)
        $fell(avec_n) |-> $past(qual_q && dtack_lvl && !as_n));

    // R5: strobe high removes the request on that edge
    p_release_r5: assert property (@(negedge clk8) disable iff (!rst_n)
        as_n |=> avec_n);

    // R6: once dropped inside a strobe-low interval, it stays off while the strobe is low
    p_single_r6: assert property (@(negedge clk8) disable iff (!rst_n)
        ($rose(avec_n) && !as_n) |=> avec_n);

    // R1: reset holds the request off
    p_reset_r1: assert property (@(negedge clk8)
        !rst_n |-> avec_n);

endmodule

// File: rtl/avec_ack_gen.sv
module avec_ack_gen #(
    parameter int FC_W   = avec_pkg::FC_W,
    parameter int ADDR_W = avec_pkg::ADDR_W
) (
    input  logic              clk8,
    input  logic              rst_n,
    input  logic [FC_W-1:0]   fc,
    input  logic [ADDR_W-1:0] addr_hi,
    input  logic              vpa_n,
    input  logic              as_n,
    input  logic              dtack_lvl,
    output logic              avec_n
);

    logic qual_q;

    avec_qualify #(.FC_W(FC_W), .ADDR_W(ADDR_W)) u_qual (
        .clk8    (clk8),
        .rst_n   (rst_n),
        .fc      (fc),
        .addr_hi (addr_hi),
        .vpa_n   (vpa_n),
        .qual_q  (qual_q)
    );

    avec_lockout_fsm u_fsm (
        .clk8      (clk8),
        .rst_n     (rst_n),
        .qual_q    (qual_q),
        .dtack_lvl (dtack_lvl),
        .as_n      (as_n),
        .avec_n    (avec_n)
    );

    // R3: the request is never present without the strobe having been low one edge earlier
    p_latency_r3: assert property (@(negedge clk8) disable iff (!rst_n)
        !avec_n |-> $past(!as_n));

endmodule

// File: tb/avec_ack_gen_tb.sv
module avec_ack_gen_tb;

    logic       clk8 = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] fc = 3'd0;
    logic [3:0] addr_hi = 4'd0;
    logic       vpa_n = 1'b1;
    logic       as_n = 1'b1;
    logic       dtack_lvl = 1'b1;
    logic       avec_n;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state: 0 idle, 1 driving, 2 locked
    int   m_st = 0;
    logic m_q1 = 1'b0;
    int   act_pulses = 0;
    int   exp_pulses = 0;
    logic prev_act = 1'b1;
    logic prev_exp = 1'b1;

    always #4 clk8 = ~clk8;

    avec_ack_gen u_dut (
        .clk8(clk8), .rst_n(rst_n), .fc(fc), .addr_hi(addr_hi),
        .vpa_n(vpa_n), .as_n(as_n), .dtack_lvl(dtack_lvl), .avec_n(avec_n)
    );

    function automatic logic exp_avec_n(input int st);
        return (st != 1);
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive after rising edge, model and compare after falling edge
    task automatic beat(input logic a_v, input logic v_v, input logic d_v,
                        input logic [2:0] f_v, input logic [3:0] ad_v, input string tag);
        logic fire;
        @(posedge clk8); #1;
        as_n = a_v; vpa_n = v_v; dtack_lvl = d_v; fc = f_v; addr_hi = ad_v;
        @(negedge clk8); #1;
        fire = m_q1 && d_v && !a_v;
        case (m_st)
            0: if (fire) m_st = 1;
            1: if (a_v) m_st = 0; else if (!fire) m_st = 2;
            default: if (a_v) m_st = 0;
        endcase
        m_q1 = (f_v == 3'b111) && (ad_v == 4'b1111) && !v_v;
        chk(avec_n, exp_avec_n(m_st), tag);
        if (prev_act && !avec_n) act_pulses++;
        if (prev_exp && !exp_avec_n(m_st)) exp_pulses++;
        prev_act = avec_n;
        prev_exp = exp_avec_n(m_st);
    endtask

    task automatic window_start();
        act_pulses = 0;
        exp_pulses = 0;
    endtask

    task automatic window_end(input string tag);
        chk_int(act_pulses, exp_pulses, tag);
        n_tests++;
        if (act_pulses > 1) begin
            n_fail++;
            $display("FAIL R6: actual %0d pulses expected at most 1", act_pulses);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h5A17);

        // R1: reset holds request high even with firing inputs
        as_n = 0; vpa_n = 0; fc = 3'b111; addr_hi = 4'hF; dtack_lvl = 1;
        repeat (3) @(negedge clk8);
        #1 chk(avec_n, 1'b1, "R1 reset");
        @(posedge clk8); #1;
        as_n = 1; vpa_n = 1; fc = 0; addr_hi = 0;
        rst_n = 1;
        beat(1, 1, 1, 3'd0, 4'd0, "R1 idle");

        // R3: exact latency
        window_start();
        beat(0, 0, 1, 3'b111, 4'hF, "R3 edge N");
        chk(avec_n, 1'b1, "R3 high after edge N");
        beat(0, 0, 1, 3'b111, 4'hF, "R3 edge N+1");
        chk(avec_n, 1'b0, "R3 low after edge N+1");
        beat(0, 0, 1, 3'b111, 4'hF, "R3 hold");
        // R5: release on first edge with strobe high
        beat(1, 1, 1, 3'b111, 4'hF, "R5 release");
        chk(avec_n, 1'b1, "R5 released");
        window_end("R6 directed");

        // R8: back-to-back acknowledge with one idle clock
        window_start();
        beat(0, 0, 1, 3'b111, 4'hF, "R8 a");
        beat(0, 0, 1, 3'b111, 4'hF, "R8 b");
        chk(avec_n, 1'b0, "R8 second cycle fires");
        beat(1, 1, 1, 3'b111, 4'hF, "R8 release");
        window_end("R8 pulses");

        // R2: each single-bit miss blocks the request
        for (int b = 0; b < 7; b++) begin
            logic [2:0] f;
            logic [3:0] a;
            f = 3'b111; a = 4'hF;
            if (b < 3) f[b] = 1'b0; else a[b-3] = 1'b0;
            window_start();
            beat(0, 0, 1, f, a, "R2 miss");
            beat(0, 0, 1, f, a, "R2 miss");
            beat(0, 0, 1, f, a, "R2 miss");
            chk(avec_n, 1'b1, "R2 no request on miss");
            beat(1, 1, 1, f, a, "R2 idle");
            window_end("R2 pulses");
        end

        // R4: legacy acknowledge low blocks the request
        window_start();
        beat(0, 0, 0, 3'b111, 4'hF, "R4 a");
        beat(0, 0, 0, 3'b111, 4'hF, "R4 b");
        beat(0, 0, 0, 3'b111, 4'hF, "R4 c");
        chk(avec_n, 1'b1, "R4 no request with dtack low");
        beat(1, 1, 1, 3'b111, 4'hF, "R4 idle");
        window_end("R4 pulses");

        // R7/R6: answer glitch must not re-fire
        window_start();
        beat(0, 0, 1, 3'b111, 4'hF, "R7 a");
        beat(0, 0, 1, 3'b111, 4'hF, "R7 b");
        chk(avec_n, 1'b0, "R7 fired");
        beat(0, 1, 1, 3'b111, 4'hF, "R7 vpa off");
        beat(0, 0, 1, 3'b111, 4'hF, "R7 vpa back");
        chk(avec_n, 1'b1, "R7 dropped after qualifier loss");
        beat(0, 0, 1, 3'b111, 4'hF, "R7 locked");
        beat(0, 0, 1, 3'b111, 4'hF, "R7 locked");
        chk(avec_n, 1'b1, "R6 no re-fire while strobe low");
        beat(1, 1, 1, 3'b111, 4'hF, "R7 idle");
        window_end("R6 glitch pulses");

        // R1: reset mid-request clears at once
        beat(0, 0, 1, 3'b111, 4'hF, "R1 pre");
        beat(0, 0, 1, 3'b111, 4'hF, "R1 pre");
        @(posedge clk8); #1 rst_n = 0;
        #1 chk(avec_n, 1'b1, "R1 async reset");
        m_st = 0; m_q1 = 0; prev_act = 1; prev_exp = 1;
        @(posedge clk8); #1 rst_n = 1; as_n = 1; vpa_n = 1;
        beat(1, 1, 1, 3'd0, 4'd0, "R1 after");

        // random bus cycles
        for (int c = 0; c < 600; c++) begin
            int kind, len, start, glitch;
            logic [2:0] f;
            logic [3:0] a;
            logic d;
            kind = $urandom % 4;
            len = 2 + ($urandom % 6);
            start = $urandom % 3;
            glitch = $urandom % 8;
            f = 3'b111; a = 4'hF; d = 1'b1;
            if (kind == 2) d = 1'b0;
            if (kind == 3) begin
                f = 3'($urandom);
                a = 4'($urandom);
                if (f == 3'b111 && a == 4'hF) a[$urandom % 4] = 1'b0;
            end
            window_start();
            for (int k = 0; k < len; k++) begin
                logic v;
                v = (k >= start) ? 1'b0 : 1'b1;
                if (k == glitch) v = 1'b1;
                if (kind == 1 && ($urandom % 5 == 0)) d = ~d;
                beat(0, v, d, f, a, "R7 random");
            end
            for (int k = 0; k < 1 + ($urandom % 2); k++)
                beat(1, 1, 1, 3'($urandom), 4'($urandom), "R5 random idle");
            window_end("R6 random pulses");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule